// File: doc/BRIEF.md
# Reference oscillator frequency classifier

This block works out which standard crystal drives a chip's reference input. It runs on the fast reference clock it is measuring. A slow 32.768 kHz timebase enters asynchronously and passes through a two-stage synchronizer. Software programs a window length in slow-clock periods, written as the period count minus one; two periods is the usual setting. Software then raises a trigger level. The block waits for the next synchronized rising edge of the slow clock and counts fast-clock cycles until the edge that closes the window. It then drops its busy flag.

After busy falls, the block holds the raw cycle count. It also compares the count against seven inclusive tolerance bands, one for each standard crystal frequency, and returns the matching frequency in kHz. A count that lands in no band reads as zero. Software clears the trigger level before it starts another measurement. All pins are plain control and status: there is no streaming data path, so no valid/ready handshake and no back-pressure.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, busy is 0, count is 0 and freq_khz is 0.
- R2: A 0-to-1 change of trig while idle starts a measurement. busy is 1 from the next cycle and stays 1 until the count is final, then returns to 0.
- R3: The window is win_len+1 slow-clock periods, where win_len is captured at the trigger. The final count equals the number of fast-clock cycles from the first synchronized slow rising edge after the trigger to the rising edge that ends the window. For a slow period of P fast cycles, the count is (win_len+1)*P.
- R4: freq_khz decodes the count through these inclusive bands:
  - 706..757 gives 12000
  - 766..820 gives 13000
  - 991..1059 gives 16800
  - 1133..1210 gives 19200
  - 1535..1638 gives 26000
  - 2268..2418 gives 38400
  - 2836..3023 gives 48000
- R5: A count outside every band of R4 gives freq_khz 0.
- R6: The count saturates at 2^CNT_W-1 instead of wrapping. With default parameters, a count past 65535 reads 65535.
- R7: trig is level-sensitive with edge start. A new rise of trig while busy is ignored, and trig held at 1 after a measurement does not start another. A measurement begins only after trig has returned to 0 and risen again.
- R8: Between measurements, count and freq_khz hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock under measurement; clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | 32.768 kHz timebase, asynchronous to clk |
| trig | input | 1 | Trigger level; its rise while idle starts a measurement |
| win_len | input | WIN_W (8) | Window length in slow periods minus one |
| busy | output | 1 | High while a measurement is in progress |
| count | output | CNT_W (16) | Fast-clock cycles counted in the last window, saturating |
| freq_khz | output | 16 | Classified frequency in kHz, 0 if no band matches |

## Verification
The assertions assume that trig is driven from the fast domain and that win_len is steady around the trigger. They also assume slow_clk is much slower than clk, so that every synchronized rising edge comes several fast cycles after the previous one. The bench keeps to these assumptions. It changes trig and slow_clk only on the falling edge of clk and uses slow periods of hundreds of fast cycles. After each change of period it waits several periods before it triggers, so that the window always sees a uniform period.

// File: rtl/osc_meas_pkg.sv
package osc_meas_pkg;
  localparam int NUM_BANDS = 7;
  localparam int FREQ_W    = 16;

  typedef logic [FREQ_W-1:0] freq_t;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ARM,
    MS_RUN
  } meas_state_e;

  localparam int unsigned BAND_LO [NUM_BANDS] = '{706, 766, 991, 1133, 1535, 2268, 2836};
  localparam int unsigned BAND_HI [NUM_BANDS] = '{757, 820, 1059, 1210, 1638, 2418, 3023};
  localparam freq_t BAND_KHZ [NUM_BANDS] =
    '{16'd12000, 16'd13000, 16'd16800, 16'd19200, 16'd26000, 16'd38400, 16'd48000};
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/osc_window_counter.sv
module osc_window_counter
  import osc_meas_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [WIN_W-1:0] win_len,
  input  logic             slow_rise,
  output logic             busy,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  meas_state_e      state;
  logic             trig_q;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] per_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= MS_IDLE;
      trig_q  <= 1'b0;
      win_q   <= '0;
      per_cnt <= '0;
      count   <= '0;
    end else begin
      trig_q <= trig;
      unique case (state)
        MS_IDLE: begin
          if (trig && !trig_q) begin
            state <= MS_ARM;
            count <= '0;
            win_q <= win_len;
          end
        end
        MS_ARM: begin
          if (slow_rise) begin
            state   <= MS_RUN;
            per_cnt <= '0;
          end
        end
        MS_RUN: begin
          if (count != CNT_MAX) count <= count + 1'b1;
          if (slow_rise) begin
            if (per_cnt == win_q) state <= MS_IDLE;
            else                  per_cnt <= per_cnt + 1'b1;
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  assign busy = (state != MS_IDLE);
endmodule

// File: rtl/osc_band_match.sv
module osc_band_match
  import osc_meas_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]     count,
  output logic [NUM_BANDS-1:0] hit,
  output freq_t                freq_khz
);
  logic [31:0] cnt_ext;
  assign cnt_ext = 32'(count);

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign hit[b] = (cnt_ext >= BAND_LO[b]) && (cnt_ext <= BAND_HI[b]);
  end

  always_comb begin
    freq_khz = '0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (hit[b]) freq_khz = freq_khz | BAND_KHZ[b];
    end
  end
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
  import osc_meas_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WIN_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             trig,
  input  logic [WIN_W-1:0] win_len,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic [FREQ_W-1:0] freq_khz
);
  logic                 slow_rise;
  logic [NUM_BANDS-1:0] band_hit;

  osc_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(slow_clk),
    .rise_o  (slow_rise)
  );

  osc_window_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .win_len  (win_len),
    .slow_rise(slow_rise),
    .busy     (busy),
    .count    (count)
  );

  osc_band_match #(.CNT_W(CNT_W)) u_match (
    .count   (count),
    .hit     (band_hit),
    .freq_khz(freq_khz)
  );
endmodule

// File: rtl/osc_freq_meter_chk.sv
module osc_freq_meter_chk
  import osc_meas_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trig,
  input logic                 busy,
  input logic [CNT_W-1:0]     count,
  input logic [FREQ_W-1:0]    freq_khz,
  input logic [NUM_BANDS-1:0] hit
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_start_on_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig));

  assert_count_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (count >= $past(count)));

  assert_one_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_zero_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) < 32'd706 || 32'(count) > 32'd3023) |-> (freq_khz == '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(count) == CMAX) |-> (count == CMAX));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(count) && $stable(freq_khz)));
endmodule

bind osc_freq_meter osc_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig    (trig),
  .busy    (busy),
  .count   (count),
  .freq_khz(freq_khz),
  .hit     (band_hit)
);

// File: tb/osc_freq_meter_test.sv
`timescale 1ns/1ps
module osc_freq_meter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        trig = 1'b0;
  logic [7:0]  win_len = 8'd1;
  logic        busy;
  logic [15:0] count;
  logic [15:0] freq_khz;

  int applied = 0;
  int bad = 0;
  int sp = 400;
  int ph = 0;
  logic prev_busy = 1'b0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  osc_freq_meter uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .trig(trig),
    .win_len(win_len), .busy(busy), .count(count), .freq_khz(freq_khz)
  );

  // slow timebase: period sp fast cycles, changes on falling clk edges
  always @(negedge clk) begin
    if (ph >= sp - 1) ph = 0;
    else              ph = ph + 1;
    slow_clk = (ph < sp / 2);
  end

  function automatic logic [15:0] band_of(input int c);
    if (c >= 706  && c <= 757)  return 16'd12000;
    if (c >= 766  && c <= 820)  return 16'd13000;
    if (c >= 991  && c <= 1059) return 16'd16800;
    if (c >= 1133 && c <= 1210) return 16'd19200;
    if (c >= 1535 && c <= 1638) return 16'd26000;
    if (c >= 2268 && c <= 2418) return 16'd38400;
    if (c >= 2836 && c <= 3023) return 16'd48000;
    return 16'd0;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    applied++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: compares each result as busy falls
  always @(negedge clk) begin
    if (prev_busy && !busy) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected result", 1, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check("R3/R6 count", int'(count), int'(e[31:16]));
        check("R4/R5 freq_khz", int'(freq_khz), int'(e[15:0]));
      end
    end
    prev_busy = busy;
  end

  task automatic run_case(input int win, input int per, input bit poke);
    int raw;
    int sat;
    sp = per;
    repeat (2 * per + 5) @(negedge clk);
    raw = (win + 1) * per;
    sat = (raw > 65535) ? 65535 : raw;
    exp_q.push_back({16'(sat), band_of(sat)});
    win_len = 8'(win);
    trig = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 busy after trigger", int'(busy), 1);
    if (poke) begin
      // R7: a second rise while busy must not disturb the measurement
      repeat (per) @(negedge clk);
      trig = 1'b0;
      win_len = 8'd200;
      repeat (2) @(negedge clk);
      trig = 1'b1;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    if (poke) begin
      // R7 and R8: trig held high starts nothing, result holds
      repeat (2 * per) @(negedge clk);
      check("R7 no restart while trig held", int'(busy), 0);
      check("R8 count holds", int'(count), sat);
      check("R8 freq holds", int'(freq_khz), int'(band_of(sat)));
    end
    trig = 1'b0;
    win_len = 8'd1;
    @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 count at reset", int'(count), 0);
    check("R1 freq at reset", int'(freq_khz), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: nominal two-period measurements, one per band
    run_case(1, 366, 1'b0);
    run_case(1, 396, 1'b0);
    run_case(1, 512, 1'b0);
    run_case(1, 586, 1'b0);
    run_case(1, 794, 1'b0);
    run_case(1, 1172, 1'b0);
    run_case(1, 1464, 1'b0);
    // R5: gap between bands
    run_case(1, 380, 1'b0);
    // R4/R5 band edges with a single-period window (R3)
    run_case(0, 706, 1'b0);
    run_case(0, 757, 1'b0);
    run_case(0, 758, 1'b0);
    run_case(0, 765, 1'b0);
    run_case(0, 1638, 1'b0);
    run_case(0, 1639, 1'b0);
    run_case(0, 3023, 1'b0);
    run_case(0, 3024, 1'b0);
    // R3: longer window
    run_case(3, 400, 1'b0);
    // R7: retrigger while busy ignored
    run_case(1, 512, 1'b1);
    // R6: saturation
    run_case(255, 260, 1'b0);
    check("R2 all results seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule